// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state update that happens when a processor takes a general exception or a debug exception. Each cycle it looks at a general exception request with its cause code and an optional faulting address. It also looks at a debug request with its own cause code, the current PC, the current processor status word and the current interrupt level. From these it decides whether an entry happens and which kind it is. The target is a kernel, user, double-exception or debug vector.

On an entry the block writes the cause registers and stores the return PC into the correct save register. On a debug entry it also keeps a copy of the old status word. It produces the new status word and emits a one-cycle take pulse together with a vector-select code, so the fetch logic can redirect. The special registers live inside the block and can be read at any time through a combinational read port selected by index.

The status word fields used are:

- interrupt level in bits [3:0]
- exception-mode flag in bit 4
- user-mode flag in bit 5

All other status bits pass through unchanged.

Top module: `exc_entry_seq`

## Requirements
- R1: A general exception taken while status bit 4 (exception mode) is set uses vector code 3 (double). When the dedicated double-exception PC register is configured, the PC goes there (read index 2) and the level-1 PC register is left unchanged.
- R2: A general exception taken while status bit 4 is clear stores the PC in the level-1 PC register (read index 9). It uses vector code 2 (user) when status bit 5 is set and code 1 (kernel) when bit 5 is clear.
- R3: Every taken general exception writes its cause code to the cause register (read index 0). The new status word equals the old one with bit 4 set.
- R4: A taken general exception with the address-valid flag high writes the address to the fault-address register (read index 1). With the flag low, that register keeps its value.
- R5: A taken debug exception at configured level L writes the debug cause register (read index 3), stores the PC at read index 8+L and stores the old status word at read index 16+L. It uses vector code 4.
- R6: On debug entry the new status word has bits [3:0] equal to L and bit 4 set, with all other bits copied unchanged.
- R7: A debug request is ignored when the current interrupt level is not strictly below L. In that case there is no take, and the debug registers, the save registers and the status output are unchanged.
- R8: When a debug request that qualifies and a general request arrive in the same cycle, only the debug entry happens. The general request is dropped and does not appear later.
- R9: The take pulse and vector code appear in the cycle after the request edge, together with the register updates. A cycle with no accepted request gives take 0 and vector code 0.
- R10: After reset, take is 0, the vector code is 0, the status output is 0 and every readable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | General exception request |
| exc_cause_i | input | CAUSE_W | General exception cause code |
| exc_addr_vld_i | input | 1 | Request carries a faulting address |
| exc_addr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request |
| dbg_cause_i | input | CAUSE_W | Debug cause code |
| pc_i | input | XLEN | PC of the excepting instruction |
| ps_i | input | XLEN | Current status word |
| cur_intlevel_i | input | LVL_W | Current interrupt level |
| rd_sel_i | input | 5 | Special register read index |
| rd_data_o | output | XLEN | Read data for rd_sel_i |
| take_o | output | 1 | One-cycle entry pulse |
| vec_o | output | 3 | Vector code: 0 none, 1 kernel, 2 user, 3 double, 4 debug |
| ps_o | output | XLEN | New status word, valid with take_o and held afterwards |

## Verification
The assertions assume that the status word and the interrupt level are stable and meaningful whenever a request is high. They also assume that the configured debug level lies between 2 and the number of levels. The stimulus drives every request input only on the falling edge and holds it for exactly one clock. It uses the default configuration, with level 6 and the double-exception register present. Interrupt levels are chosen both below and at or above the debug level, so that the ignore condition is reached from both sides of the boundary and the priority rule is exercised.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
  localparam int SEL_W        = 5;
  localparam int SEL_CAUSE    = 0;
  localparam int SEL_VADDR    = 1;
  localparam int SEL_DEPC     = 2;
  localparam int SEL_DBGCAUSE = 3;
  localparam int SEL_EPC_BASE = 8;
  localparam int SEL_EPS_BASE = 16;

  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_KERNEL = 3'd1,
    VEC_USER   = 3'd2,
    VEC_DOUBLE = 3'd3,
    VEC_DEBUG  = 3'd4
  } vec_e;

  typedef struct packed {
    logic take;
    vec_e vec;
    logic wr_cause;
    logic wr_vaddr;
    logic wr_depc;
    logic wr_epc1;
    logic wr_dbg;
  } upd_t;
endpackage

// File: rtl/exc_decide.sv
module exc_decide
  import exc_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic             exc_req_i,
  input  logic             exc_addr_vld_i,
  input  logic             dbg_req_i,
  input  logic [XLEN-1:0]  ps_i,
  input  logic [LVL_W-1:0] cur_intlevel_i,
  output upd_t             upd_o,
  output logic [XLEN-1:0]  ps_new_o
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DBG_LEVEL);

  logic dbg_ok;
  assign dbg_ok = dbg_req_i && (cur_intlevel_i < DBG_LVL);

  always_comb begin
    upd_o    = '0;
    upd_o.vec = VEC_NONE;
    ps_new_o = ps_i;
    if (dbg_ok) begin
      // debug has priority; general request is dropped
      upd_o.take   = 1'b1;
      upd_o.vec    = VEC_DEBUG;
      upd_o.wr_dbg = 1'b1;
      ps_new_o[LVL_W-1:0]   = DBG_LVL;
      ps_new_o[PS_EXCM_BIT] = 1'b1;
    end else if (exc_req_i) begin
      upd_o.take     = 1'b1;
      upd_o.wr_cause = 1'b1;
      upd_o.wr_vaddr = exc_addr_vld_i;
      ps_new_o[PS_EXCM_BIT] = 1'b1;
      if (ps_i[PS_EXCM_BIT]) begin
        upd_o.vec = VEC_DOUBLE;
        if (HAS_DEPC) upd_o.wr_depc = 1'b1;
        else          upd_o.wr_epc1 = 1'b1;
      end else begin
        upd_o.wr_epc1 = 1'b1;
        upd_o.vec     = ps_i[PS_UM_BIT] ? VEC_USER : VEC_KERNEL;
      end
    end
  end
endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file
  import exc_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int NLEVELS   = 7,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  upd_t               upd_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    ps_i,
  input  logic [XLEN-1:0]    exc_addr_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [XLEN-1:0]    rd_data_o
);
  logic [CAUSE_W-1:0] cause_q, dbg_cause_q;
  logic [XLEN-1:0]    vaddr_q, depc_rd;
  logic [XLEN-1:0]    epc_rd [1:NLEVELS];
  logic [XLEN-1:0]    eps_rd [1:NLEVELS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q     <= '0;
      dbg_cause_q <= '0;
      vaddr_q     <= '0;
    end else begin
      if (upd_i.wr_cause) cause_q     <= exc_cause_i;
      if (upd_i.wr_dbg)   dbg_cause_q <= dbg_cause_i;
      if (upd_i.wr_vaddr) vaddr_q     <= exc_addr_i;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            q <= '0;
        else if (upd_i.wr_depc) q <= pc_i;
      end
      assign depc_rd = q;
    end else begin : g_no_depc
      assign depc_rd = '0;
    end

    for (genvar k = 1; k <= NLEVELS; k++) begin : g_lvl
      if (k == 1 || k == DBG_LEVEL) begin : g_epc
        logic [XLEN-1:0] q;
        logic            we;
        assign we = (k == 1 && upd_i.wr_epc1) || (k == DBG_LEVEL && upd_i.wr_dbg);
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)  q <= '0;
          else if (we)  q <= pc_i;
        end
        assign epc_rd[k] = q;
      end else begin : g_epc_none
        assign epc_rd[k] = '0;
      end
      if (k == DBG_LEVEL && k >= 2) begin : g_eps
        logic [XLEN-1:0] q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)           q <= '0;
          else if (upd_i.wr_dbg) q <= ps_i;
        end
        assign eps_rd[k] = q;
      end else begin : g_eps_none
        assign eps_rd[k] = '0;
      end
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    case (int'(rd_sel_i))
      SEL_CAUSE:    rd_data_o = XLEN'(cause_q);
      SEL_VADDR:    rd_data_o = vaddr_q;
      SEL_DEPC:     rd_data_o = depc_rd;
      SEL_DBGCAUSE: rd_data_o = XLEN'(dbg_cause_q);
      default: begin
        for (int k = 1; k <= NLEVELS; k++) begin
          if (int'(rd_sel_i) == SEL_EPC_BASE + k) rd_data_o = epc_rd[k];
          if (int'(rd_sel_i) == SEL_EPS_BASE + k) rd_data_o = eps_rd[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int LVL_W     = 4,
  parameter int NLEVELS   = 7,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               exc_addr_vld_i,
  input  logic [XLEN-1:0]    exc_addr_i,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    ps_i,
  input  logic [LVL_W-1:0]   cur_intlevel_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [XLEN-1:0]    rd_data_o,
  output logic               take_o,
  output logic [2:0]         vec_o,
  output logic [XLEN-1:0]    ps_o
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DBG_LEVEL);

  upd_t            upd;
  logic [XLEN-1:0] ps_new;
  logic            take_q;
  vec_e            vec_q;
  logic [XLEN-1:0] ps_q;

  exc_decide #(
    .XLEN(XLEN), .LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)
  ) u_decide (
    .exc_req_i      (exc_req_i),
    .exc_addr_vld_i (exc_addr_vld_i),
    .dbg_req_i      (dbg_req_i),
    .ps_i           (ps_i),
    .cur_intlevel_i (cur_intlevel_i),
    .upd_o          (upd),
    .ps_new_o       (ps_new)
  );

  exc_sreg_file #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .NLEVELS(NLEVELS),
    .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)
  ) u_sregs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (upd),
    .pc_i        (pc_i),
    .ps_i        (ps_i),
    .exc_addr_i  (exc_addr_i),
    .exc_cause_i (exc_cause_i),
    .dbg_cause_i (dbg_cause_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= VEC_NONE;
      ps_q   <= '0;
    end else begin
      take_q <= upd.take;
      vec_q  <= upd.vec;
      if (upd.take) ps_q <= ps_new;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign ps_o   = ps_q;

  AST_DOUBLE_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !dbg_req_i && ps_i[PS_EXCM_BIT]) |=> (take_o && vec_o == VEC_DOUBLE)); // R1
  AST_EXCM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ps_o[PS_EXCM_BIT]); // R3
  AST_DBG_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vec_o == VEC_DEBUG) |-> (ps_o[LVL_W-1:0] == DBG_LVL)); // R6
  AST_DBG_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !exc_req_i && cur_intlevel_i >= DBG_LVL) |=> !take_o); // R7
  AST_DBG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && exc_req_i && cur_intlevel_i < DBG_LVL) |=> (vec_o == VEC_DEBUG)); // R8
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_req_i && !dbg_req_i) |=> (!take_o && vec_o == VEC_NONE)); // R9
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int DBG_L = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0, exc_addr_vld = 1'b0, dbg_req = 1'b0;
  logic [5:0]  exc_cause = '0, dbg_cause = '0;
  logic [31:0] exc_addr = '0, pc = '0, ps = '0;
  logic [3:0]  lvl = '0;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd_data, ps_out;
  logic        take;
  logic [2:0]  vec;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        take;
    logic [2:0]  vec;
    logic [31:0] ps;
    string       tag;
  } exp_t;
  exp_t        sb_q[$];
  logic [31:0] model [0:31];

  always #10 clk = ~clk;

  exc_entry_seq #(.DBG_LEVEL(DBG_L)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_req_i(exc_req), .exc_cause_i(exc_cause),
    .exc_addr_vld_i(exc_addr_vld), .exc_addr_i(exc_addr),
    .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause),
    .pc_i(pc), .ps_i(ps), .cur_intlevel_i(lvl),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .take_o(take), .vec_o(vec), .ps_o(ps_out)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: applies one request for one cycle and pushes the expectation
  task automatic drive(input logic e_req, input logic [5:0] e_cause,
                       input logic a_vld, input logic [31:0] a,
                       input logic d_req, input logic [5:0] d_cause,
                       input logic [31:0] p, input logic [31:0] s,
                       input logic [3:0] l, input string tag);
    exp_t e;
    @(negedge clk);
    exc_req = e_req; exc_cause = e_cause; exc_addr_vld = a_vld; exc_addr = a;
    dbg_req = d_req; dbg_cause = d_cause; pc = p; ps = s; lvl = l;
    e.tag = tag; e.take = 1'b0; e.vec = 3'd0; e.ps = 32'h0;
    if (d_req && l < DBG_L) begin
      e.take = 1'b1; e.vec = 3'd4;
      e.ps = (s & ~32'hF) | 32'(DBG_L) | 32'h10;
      model[3] = 32'(d_cause);
      model[8 + DBG_L] = p;
      model[16 + DBG_L] = s;
    end else if (e_req) begin
      e.take = 1'b1;
      e.ps = s | 32'h10;
      model[0] = 32'(e_cause);
      if (a_vld) model[1] = a;
      if (s[4]) begin
        e.vec = 3'd3; model[2] = p;
      end else begin
        e.vec = s[5] ? 3'd2 : 3'd1; model[9] = p;
      end
    end
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exc_req = 1'b0; dbg_req = 1'b0; exc_addr_vld = 1'b0;
    end
  endtask

  task automatic check_regs(input string tag);
    for (int s = 0; s < 32; s++) begin
      rd_sel = 5'(s);
      #1;
      check(rd_data === model[s], tag, $sformatf("reg[%0d]", s), rd_data, model[s]);
    end
  endtask

  // monitor: compares outputs against the scoreboard after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check(take === e.take, e.tag, "take", 32'(take), 32'(e.take));
          check(vec === e.vec, e.tag, "vec", 32'(vec), 32'(e.vec));
          if (e.take) check(ps_out === e.ps, e.tag, "ps", ps_out, e.ps);
        end else begin
          check(take === 1'b0 && vec === 3'd0, "R9", "idle take/vec",
                {29'd0, vec}, 32'd0);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    #2;
    // R10: reset state
    check(take === 1'b0, "R10", "take", 32'(take), 32'd0);
    check(vec === 3'd0, "R10", "vec", 32'(vec), 32'd0);
    check(ps_out === 32'd0, "R10", "ps", ps_out, 32'd0);
    check_regs("R10");
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4: kernel entry with address
    drive(1, 6'd5, 1, 32'hDEAD_B000, 0, 6'd0, 32'h0000_1000, 32'h0000_0003, 4'd3, "R2_kernel");
    idle(2);
    check_regs("R2_R3_R4");

    // R2 R4: user entry without address, extra status bit kept
    drive(1, 6'd9, 0, 32'h1111_2222, 0, 6'd0, 32'h0000_2000, 32'h0000_0120, 4'd0, "R2_user");
    idle(2);
    check_regs("R4_noaddr");

    // R1: double exception, level-1 PC register untouched
    drive(1, 6'd12, 1, 32'h0BAD_0040, 0, 6'd0, 32'h0000_3000, 32'h0000_0030, 4'd1, "R1_double");
    idle(2);
    check_regs("R1");

    // R5 R6: debug entry below the level
    drive(0, 6'd0, 0, 32'h0, 1, 6'd33, 32'h0000_4000, 32'h0000_0125, 4'd2, "R5_R6_debug");
    idle(2);
    check_regs("R5");

    // R7: debug ignored at and above the level
    drive(0, 6'd0, 0, 32'h0, 1, 6'd7, 32'h0000_5000, 32'h0000_0001, 4'd6, "R7_at_level");
    drive(0, 6'd0, 0, 32'h0, 1, 6'd8, 32'h0000_5004, 32'h0000_0002, 4'd15, "R7_above");
    idle(2);
    check_regs("R7");

    // R7: ignored debug with a general request lets the general one through
    drive(1, 6'd21, 1, 32'hCAFE_0000, 1, 6'd3, 32'h0000_6000, 32'h0000_0007, 4'd7, "R7_gen_passes");
    idle(2);
    check_regs("R7_gen");

    // R8: simultaneous requests, debug wins, general dropped
    drive(1, 6'd40, 1, 32'h7777_0000, 1, 6'd44, 32'h0000_7000, 32'h0000_0004, 4'd0, "R8_prio");
    idle(3);
    check_regs("R8");

    // R9: back-to-back entries each produce their own pulse
    drive(1, 6'd1, 0, 32'h0, 0, 6'd0, 32'h0000_8000, 32'h0000_0000, 4'd0, "R9_b2b_a");
    drive(1, 6'd2, 1, 32'h0000_8888, 0, 6'd0, 32'h0000_8004, 32'h0000_0020, 4'd0, "R9_b2b_b");
    drive(0, 6'd0, 0, 32'h0, 0, 6'd0, 32'h0, 32'h0, 4'd0, "R9_none");
    idle(3);
    check_regs("R9");

    finish_run();
  end
endmodule